// File: doc/BRIEF.md
# Scheduler-Aware Page Prefetch Manager

This block sits beside a GPU warp scheduler and watches the memory instructions it issues. Loads and stores that missed both on-chip cache levels are reduced to 4 KB page numbers. Each page number is kept once in a small insertion-ordered table. Nothing moves toward device DRAM while pages are only being collected.

When a demand access misses in device DRAM, the block first requests the page that missed. It then walks the table and issues one page-fetch request for every recorded page. A page is skipped if a combinational residency lookup reports it already present in DRAM, or if it equals the missed page. After the walk the table and its overflow flag are cleared. Observations are held off with a busy output while the walk runs.

Top module: `sched_prefetch_mgr`

## Requirements
- R1: An observation is recorded only when its opcode class is load (code 1) or store (code 2); every other opcode class value leaves the table unchanged.
- R2: An observation whose cache-hit flag is 1 is not recorded.
- R3: A recorded page number is the address shifted right by 12; addresses in the same 4 KB page share one table entry, and addresses on either side of a 4 KB boundary give two entries.
- R4: No request is offered (`pf_valid` low) until a DRAM miss has been sampled.
- R5: On the cycle after a miss is sampled while idle, the missed page is offered as the first request, whether or not it was recorded.
- R6: The requests that follow come from table entries in insertion order, one per accepted handshake. An entry is skipped when `res_hit` answers 1 for it or when it equals the missed page. While `pf_ready` is low, `pf_valid` and `pf_page` are held.
- R7: After the last request, the table and the overflow flag are cleared, so a later miss offers only what was recorded after it.
- R8: The table holds 16 entries. A new unique page arriving when it is full is dropped and sets the sticky `ovf_flag`; the flag never rises during a walk.
- R9: `obs_busy` is high from a miss until one cycle after the walk ends, and observations presented while it is high are not recorded.
- R10: Recording the addresses 2147545984, 2147560448, 2147560576 and 2147560704 and then missing at 2147545984 yields exactly two requests: 524303, then 524306.
- R11: A synchronous active-low reset empties the table, clears `ovf_flag` and returns the walk to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obs_valid | input | 1 | Scheduler instruction observation present |
| obs_opc | input | 3 | Opcode class (1 load, 2 store, others ignored) |
| obs_addr | input | 32 | Byte address accessed by the instruction |
| obs_cache_hit | input | 1 | Instruction hit in L1 or L2 |
| obs_busy | output | 1 | Observations are not accepted this cycle |
| miss_valid | input | 1 | Demand access missed in device DRAM |
| miss_addr | input | 32 | Address of the missing access |
| res_query_valid | output | 1 | Residency lookup active |
| res_query_page | output | 20 | Page number being looked up |
| res_hit | input | 1 | Looked-up page is resident (combinational answer) |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_page | output | 20 | Page number to fetch from flash |
| ovf_flag | output | 1 | Sticky: a unique page was dropped because the table was full |

## Verification
An observation enters the table at the rising edge that samples it. The missed page is offered one cycle after the miss is sampled. Each later request appears either one cycle after the previous handshake or one cycle per skipped entry, and `obs_busy` drops one cycle after the final handshake. The bench drives inputs 1 ns after a rising edge and samples outputs at the falling edge. A monitor there pops the expected page from a queue on every handshake, so it checks the offered page and the order of requests without having to predict the exact cycle of each one. When the walk is over, the count of handshakes is compared with the number of pages that were expected.

// File: rtl/spm_pkg.sv
// Shared definitions for the scheduler-aware page prefetch manager.
// Assumes a 3-bit opcode class field coming from the warp scheduler.
package spm_pkg;
    localparam int OPC_W = 3;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 3'd1;
    localparam logic [OPC_W-1:0] OPC_STORE = 3'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MISS  = 2'd1,
        ST_TABLE = 2'd2
    } drain_state_t;

    // True for the instruction classes that move data to or from memory
    function automatic logic is_mem_op(input logic [OPC_W-1:0] opc);
        return (opc == OPC_LOAD) || (opc == OPC_STORE);
    endfunction
endpackage

// File: rtl/spm_obs_filter.sv
// Observation filter: qualifies a scheduler observation for recording and
// reduces its address to a page number. Purely combinational.
// Assumes the caller blocks observations with 'hold' while a walk runs.
module spm_obs_filter #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic                      obs_valid,
    input  logic [spm_pkg::OPC_W-1:0] obs_opc,
    input  logic [ADDR_W-1:0]         obs_addr,
    input  logic                      obs_cache_hit,
    input  logic                      hold,
    output logic                      rec_valid,
    output logic [PAGE_W-1:0]         rec_page
);
    // Qualify: memory op, missed both caches, not held off
    always_comb begin
        rec_valid = obs_valid && !hold && spm_pkg::is_mem_op(obs_opc) && !obs_cache_hit;
        rec_page  = PAGE_W'(obs_addr >> PAGE_SHIFT);
    end
endmodule

// File: rtl/spm_page_table.sv
// Page table: insertion-ordered list of unique page numbers with a valid
// bit per entry and a fully parallel duplicate compare. Drops new unique
// pages when full and raises a sticky overflow flag. 'clear' empties it.
// Assumes insert and clear are never requested in the same cycle.
module spm_page_table #(
    parameter int PAGE_W  = 20,
    parameter int DEPTH   = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [PAGE_W-1:0] ins_page,
    input  logic              clear,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  count,
    output logic [PAGE_W-1:0] rd_page,
    output logic              ovf
);
    logic [PAGE_W-1:0] pages [DEPTH];
    logic [DEPTH-1:0]  valid;
    logic [DEPTH-1:0]  match;
    logic              dup;
    logic              full;
    logic              do_write;

    // Per-entry compare and storage
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign match[g] = valid[g] && (pages[g] == ins_page);

        // Entry payload: written when this slot is the next free one
        always_ff @(posedge clk) begin
            if (do_write && (count == CNT_W'(g))) begin
                pages[g] <= ins_page;
            end
        end

        // Entry valid bit: set on write, cleared by reset or flush
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                valid[g] <= 1'b0;
            end else if (do_write && (count == CNT_W'(g))) begin
                valid[g] <= 1'b1;
            end
        end
    end

    // Insert decision from the parallel compare and fill level
    always_comb begin
        dup      = |match;
        full     = (count == CNT_W'(DEPTH));
        do_write = ins_valid && !dup && !full;
    end

    // Fill level and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (ins_valid && !dup) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // Read mux for the walk
    always_comb begin
        rd_page = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == CNT_W'(i)) begin
                rd_page = pages[i];
            end
        end
    end
endmodule

// File: rtl/spm_drain_fsm.sv
// Drain controller: on a DRAM miss it offers the missed page, then walks
// the table in order, skipping resident pages and the missed page, one
// request per handshake; then it flushes the table and returns to idle.
// Assumes res_hit answers combinationally for rd_page.
module spm_drain_fsm #(
    parameter int PAGE_W = 20,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [PAGE_W-1:0] miss_page,
    input  logic [CNT_W-1:0]  count,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic              res_hit,
    input  logic              pf_ready,
    output logic              drain_idle,
    output logic [CNT_W-1:0]  rd_idx,
    output logic              tbl_clear,
    output logic              res_query_valid,
    output logic              pf_valid,
    output logic [PAGE_W-1:0] pf_page
);
    import spm_pkg::*;

    drain_state_t      state_q;
    logic [CNT_W-1:0]  idx_q;
    logic [PAGE_W-1:0] miss_q;
    logic              in_tbl;
    logic              at_end;
    logic              skip;

    // Walk-phase decode and outputs
    always_comb begin
        in_tbl          = (state_q == ST_TABLE);
        at_end          = (idx_q == count);
        skip            = res_hit || (rd_page == miss_q);
        res_query_valid = in_tbl && !at_end;
        tbl_clear       = in_tbl && at_end;
        pf_valid        = (state_q == ST_MISS) || (in_tbl && !at_end && !skip);
        pf_page         = (state_q == ST_MISS) ? miss_q : rd_page;
        drain_idle      = (state_q == ST_IDLE);
        rd_idx          = idx_q;
    end

    // State, walk index and captured miss page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            miss_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        miss_q  <= miss_page;
                        idx_q   <= '0;
                        state_q <= ST_MISS;
                    end
                end
                ST_MISS: begin
                    if (pf_ready) begin
                        state_q <= ST_TABLE;
                    end
                end
                ST_TABLE: begin
                    if (at_end) begin
                        idx_q   <= '0;
                        state_q <= ST_IDLE;
                    end else if (skip || pf_ready) begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sched_prefetch_mgr.sv
// Scheduler-aware page prefetch manager top. Records unique 4 KB pages of
// cache-missing loads/stores seen at the warp scheduler and, on a device
// DRAM miss, issues the missed page and then every non-resident recorded
// page as prefetch requests, then flushes. Assumes a single clock domain.
module sched_prefetch_mgr #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int DEPTH      = 16,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      obs_valid,
    input  logic [spm_pkg::OPC_W-1:0] obs_opc,
    input  logic [ADDR_W-1:0]         obs_addr,
    input  logic                      obs_cache_hit,
    output logic                      obs_busy,
    input  logic                      miss_valid,
    input  logic [ADDR_W-1:0]         miss_addr,
    output logic                      res_query_valid,
    output logic [PAGE_W-1:0]         res_query_page,
    input  logic                      res_hit,
    output logic                      pf_valid,
    input  logic                      pf_ready,
    output logic [PAGE_W-1:0]         pf_page,
    output logic                      ovf_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              rec_valid;
    logic [PAGE_W-1:0] rec_page;
    logic              drain_idle;
    logic              tbl_clear;
    logic [CNT_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  count;
    logic [PAGE_W-1:0] rd_page;
    logic [PAGE_W-1:0] miss_page;

    // Busy while walking or while a miss is being taken
    always_comb begin
        obs_busy       = !drain_idle || miss_valid;
        miss_page      = PAGE_W'(miss_addr >> PAGE_SHIFT);
        res_query_page = rd_page;
    end

    spm_obs_filter #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_filter (
        .obs_valid    (obs_valid),
        .obs_opc      (obs_opc),
        .obs_addr     (obs_addr),
        .obs_cache_hit(obs_cache_hit),
        .hold         (obs_busy),
        .rec_valid    (rec_valid),
        .rec_page     (rec_page)
    );

    spm_page_table #(
        .PAGE_W(PAGE_W),
        .DEPTH (DEPTH)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_valid(rec_valid),
        .ins_page (rec_page),
        .clear    (tbl_clear),
        .rd_idx   (rd_idx),
        .count    (count),
        .rd_page  (rd_page),
        .ovf      (ovf_flag)
    );

    spm_drain_fsm #(
        .PAGE_W(PAGE_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_page      (miss_page),
        .count          (count),
        .rd_page        (rd_page),
        .res_hit        (res_hit),
        .pf_ready       (pf_ready),
        .drain_idle     (drain_idle),
        .rd_idx         (rd_idx),
        .tbl_clear      (tbl_clear),
        .res_query_valid(res_query_valid),
        .pf_valid       (pf_valid),
        .pf_page        (pf_page)
    );
endmodule

// File: rtl/spm_checker.sv
// Property checker for sched_prefetch_mgr, attached with bind below.
// Observes ports plus the walk-idle signal driven by the drain controller.
module spm_checker #(
    parameter int PAGE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drain_idle,
    input logic              miss_valid,
    input logic [PAGE_W-1:0] miss_page,
    input logic              obs_busy,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [PAGE_W-1:0] pf_page,
    input logic              ovf_flag
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!pf_valid && !ovf_flag && drain_idle)); // R11

    AST_QUIET_UNTIL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        drain_idle |-> !pf_valid); // R4

    AST_MISS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_idle && miss_valid) |=> (pf_valid && pf_page == $past(miss_page))); // R5

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_page))); // R6

    AST_BUSY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !drain_idle |-> obs_busy); // R9

    AST_NO_OVERFLOW_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> drain_idle); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && drain_idle && !miss_valid) |=> ovf_flag); // R8
endmodule

bind sched_prefetch_mgr spm_checker #(
    .PAGE_W(PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drain_idle(drain_idle),
    .miss_valid(miss_valid),
    .miss_page (miss_page),
    .obs_busy  (obs_busy),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_page   (pf_page),
    .ovf_flag  (ovf_flag)
);

// File: tb/sched_prefetch_mgr_tb.sv
`timescale 1ns/1ps
module sched_prefetch_mgr_tb;
    localparam int AW = 32;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          obs_valid = 1'b0;
    logic [2:0]    obs_opc = '0;
    logic [AW-1:0] obs_addr = '0;
    logic          obs_cache_hit = 1'b0;
    logic          obs_busy;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          res_query_valid;
    logic [PW-1:0] res_query_page;
    logic          res_hit;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [PW-1:0] pf_page;
    logic          ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int hs_cnt = 0;

    logic [PW-1:0] exp_q[$];
    string         tag_q[$];
    logic [PW-1:0] mdl_tab[16];
    int            mdl_n = 0;
    logic [PW-1:0] res_set[4];
    int            res_n = 0;

    always #2 clk = ~clk;

    sched_prefetch_mgr u_dut (
        .clk(clk), .rst_n(rst_n),
        .obs_valid(obs_valid), .obs_opc(obs_opc), .obs_addr(obs_addr),
        .obs_cache_hit(obs_cache_hit), .obs_busy(obs_busy),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .res_query_valid(res_query_valid), .res_query_page(res_query_page),
        .res_hit(res_hit),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_page(pf_page),
        .ovf_flag(ovf_flag)
    );

    // Residency responder
    always_comb begin
        res_hit = 1'b0;
        for (int i = 0; i < 4; i++)
            if (i < res_n && res_set[i] == res_query_page) res_hit = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Monitor: scoreboard pop on every accepted request
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            hs_cnt++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected request: actual %0d expected none", pf_page);
            end else begin
                automatic logic [PW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (pf_page !== e) begin
                    n_fail++;
                    $display("FAIL %s request page: actual %0d expected %0d", t, pf_page, e);
                end
            end
        end
    end

    function automatic bit is_res(input logic [PW-1:0] p);
        for (int i = 0; i < res_n; i++) if (res_set[i] == p) return 1'b1;
        return 1'b0;
    endfunction

    // Driver: one observation cycle, with model update
    task automatic observe(input logic [2:0] opc, input logic [AW-1:0] a, input bit hit);
        automatic logic [PW-1:0] p = PW'(a >> 12);
        automatic bit found = 1'b0;
        obs_valid = 1'b1; obs_opc = opc; obs_addr = a; obs_cache_hit = hit;
        @(posedge clk); #1;
        obs_valid = 1'b0;
        if ((opc == 3'd1 || opc == 3'd2) && !hit) begin
            for (int i = 0; i < mdl_n; i++) if (mdl_tab[i] == p) found = 1'b1;
            if (!found && mdl_n < 16) begin
                mdl_tab[mdl_n] = p;
                mdl_n++;
            end
        end
    endtask

    // Driver: a DRAM miss, expected pages pushed, drain followed to the end
    task automatic do_miss(input logic [AW-1:0] a, input bit stall, input string tag,
                           input bit inject, input logic [AW-1:0] inj_addr);
        automatic logic [PW-1:0] mp = PW'(a >> 12);
        automatic int nexp = 1;
        automatic int guard = 0;
        exp_q.push_back(mp); tag_q.push_back("R5");
        for (int i = 0; i < mdl_n; i++) begin
            if (mdl_tab[i] != mp && !is_res(mdl_tab[i])) begin
                exp_q.push_back(mdl_tab[i]); tag_q.push_back(tag);
                nexp++;
            end
        end
        mdl_n = 0;
        hs_cnt = 0;
        miss_valid = 1'b1; miss_addr = a;
        @(posedge clk); #1;
        miss_valid = 1'b0;
        chk(obs_busy == 1'b1, "R9", "busy during walk", obs_busy, 1);
        if (inject) begin
            obs_valid = 1'b1; obs_opc = 3'd1; obs_addr = inj_addr; obs_cache_hit = 1'b0;
        end
        while (obs_busy && guard < 2000) begin
            pf_ready = stall ? ~pf_ready : 1'b1;
            @(posedge clk); #1;
            obs_valid = 1'b0;
            guard++;
        end
        pf_ready = 1'b1;
        @(negedge clk);
        chk(hs_cnt == nexp, tag, "request count", hs_cnt, nexp);
        chk(exp_q.size() == 0, tag, "pending expected", exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
        @(posedge clk); #1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk(pf_valid == 0, "R11", "pf_valid in reset", pf_valid, 0);
        chk(ovf_flag == 0, "R11", "ovf in reset", ovf_flag, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(obs_busy == 0, "R11", "busy after reset", obs_busy, 0);

        // R10: four addresses collapse into two pages
        observe(3'd1, 32'd2147545984, 1'b0);
        observe(3'd1, 32'd2147560448, 1'b0);
        observe(3'd2, 32'd2147560576, 1'b0);
        observe(3'd1, 32'd2147560704, 1'b0);
        repeat (3) @(posedge clk); #1;
        chk(pf_valid == 0, "R4", "no request before miss", pf_valid, 0);
        do_miss(32'd2147545984, 1'b0, "R10", 1'b0, '0);

        // R1 R2: filtered classes and cache hits, with back-pressure (R6)
        observe(3'd0, 32'h1000_0000, 1'b0);
        observe(3'd3, 32'h1100_0000, 1'b0);
        observe(3'd7, 32'h1200_0000, 1'b0);
        observe(3'd2, 32'h1300_0000, 1'b1);
        observe(3'd1, 32'h1400_0000, 1'b1);
        observe(3'd1, 32'h1500_0000, 1'b0);
        observe(3'd2, 32'h1600_0000, 1'b0);
        do_miss(32'h1700_0abc, 1'b1, "R1", 1'b0, '0);

        // R6: resident page skipped, missed page suppressed, order kept
        observe(3'd1, 32'h2000_1000, 1'b0);
        observe(3'd1, 32'h2000_2000, 1'b0);
        observe(3'd2, 32'h2000_3000, 1'b0);
        observe(3'd1, 32'h2000_4000, 1'b0);
        res_set[0] = PW'(32'h2000_2000 >> 12); res_n = 1;
        do_miss(32'h2000_3123, 1'b1, "R6", 1'b0, '0);
        res_n = 0;

        // R3: same page shares one entry, a boundary splits
        observe(3'd1, 32'h5000_0fff, 1'b0);
        observe(3'd2, 32'h5000_0000, 1'b0);
        observe(3'd1, 32'h5000_0800, 1'b0);
        observe(3'd1, 32'h5000_1000, 1'b0);
        do_miss(32'h6000_0000, 1'b0, "R3", 1'b0, '0);

        // R9: observation during a walk is dropped; R7 table flushed
        observe(3'd1, 32'h3000_0000, 1'b0);
        do_miss(32'h3100_0000, 1'b0, "R9", 1'b1, 32'h3200_0000);
        do_miss(32'h3300_0000, 1'b0, "R7", 1'b0, '0);

        // R8: overflow beyond 16 unique pages, plus a duplicate
        for (int i = 0; i < 17; i++) observe(3'd1, 32'h4000_0000 + 32'(i) * 32'd4096, 1'b0);
        observe(3'd2, 32'h4000_0010, 1'b0);
        chk(ovf_flag == 1, "R8", "overflow set", ovf_flag, 1);
        do_miss(32'h4800_0000, 1'b1, "R8", 1'b0, '0);
        chk(ovf_flag == 0, "R7", "overflow cleared by flush", ovf_flag, 0);

        // R11: reset mid-collection empties the table
        observe(3'd1, 32'h7000_0000, 1'b0);
        observe(3'd1, 32'h7000_1000, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        mdl_n = 0;
        chk(ovf_flag == 0, "R11", "ovf after reset", ovf_flag, 0);
        chk(pf_valid == 0, "R11", "pf_valid after reset", pf_valid, 0);
        do_miss(32'h7100_0000, 1'b0, "R11", 1'b0, '0);

        summary();
        $finish;
    end
endmodule